// File: doc/BRIEF.md
# Flag-Based Branch Sequencer

This block owns the program counter of a small scalar control processor. The decoder hands it one instruction per handshake: an operation code, up to three 32-bit operand values already read from the register file, a label address, two offset values, and a halt code. Compare instructions reduce their operands, or one of two external status bits, to a single sticky condition flag. Conditional jumps then read that flag.

Jump targets are the label plus one register offset, and optionally a second one. Besides the conditional jumps, the unit offers an unconditional jump, a call that hands back the return address, a read of the current PC, a fused add-and-compare that hands back the sum, and a halt.

Results meant for the register file leave on a one-cycle strobe (`wb_valid`, `wb_data`). The register file always accepts them, so that side has no back-pressure. The instruction side is valid/ready. An instruction is taken on a rising edge where `op_valid` and `op_ready` are both high. `op_ready` drops for good once a halt is taken, and only reset raises it again. The decoder must hold its instruction stable while `op_valid` is high and `op_ready` is low.

Top module: `branch_seq`

## Requirements
- R1: After reset, `pc` is 0, `flag` is 0, `halted` is 0, `halt_code` is 0, `wb_valid` is 0 and `op_ready` is 1.
- R2: Codes 0 to 5 (EQ, NE, GT, LT, GE, LE) compare `opa` against `opb` as signed 32-bit values. The flag becomes 1 if the relation holds and 0 otherwise, and `pc` advances by 1.
- R3: Code 6 (add-compare) sets the flag to (`opa`+`opb`) > `opc`, where the sum wraps to 32 bits and the compare is signed. The wrapped sum is returned on `wb_data`, and `pc` advances by 1.
- R4: Code 7 sets the flag to `gcond`, code 8 sets it to NOT `gcond`, and code 9 sets it to `status2`. Each advances `pc` by 1.
- R5: Codes 10 to 15 leave the flag unchanged.
- R6: The target is (`label` + `off0` + (`off1_en` ? `off1` : 0)) truncated to the PC width. Code 10 loads it into `pc` unconditionally.
- R7: Code 11 loads the target when the flag is 1 and otherwise goes to `pc`+1. Code 12 loads the target when the flag is 0 and otherwise goes to `pc`+1.
- R8: Code 13 (call) returns the PC of the call itself, zero-extended, on `wb_data` and loads the target. Code 14 returns the current PC and advances by 1.
- R9: `wb_valid` is high for exactly the cycle after a taken code 3'd6, 13 or 14, and low after every other cycle.
- R10: Code 15 (halt) freezes `pc`, sets `halted`, and shows `halt_code_in` on `halt_code`. From then on `op_ready` is 0 and no instruction changes any state until reset.
- R11: A cycle without a taken instruction changes neither `pc` nor `flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction present |
| op_ready | output | 1 | Unit accepts an instruction (low once halted) |
| op_code | input | 4 | Operation code, see requirements |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| opc | input | 32 | Third operand (add-compare limit) |
| label | input | PCW | Label address of a jump or call |
| off0 | input | 32 | First target offset |
| off1 | input | 32 | Second target offset |
| off1_en | input | 1 | Add the second offset |
| gcond | input | 1 | Global condition status bit |
| status2 | input | 1 | Second status bit |
| halt_code_in | input | 4 | Code recorded by a halt |
| pc | output | PCW | Program counter |
| flag | output | 1 | Condition flag |
| wb_valid | output | 1 | Write-back strobe |
| wb_data | output | 32 | Write-back value |
| halted | output | 1 | Unit halted |
| halt_code | output | 4 | Recorded halt code |

## Verification
The bench aims at signed boundaries. Cases include -1 against 1, equal operands, and an add-compare whose sum wraps past the largest positive value. A design that compared unsigned, or widened the sum, would set the wrong flag in these cases.

It also mixes jumps with compares and non-compares. A flag that leaked from a jump or halt, or a conditional jump with its sense inverted, would send `pc` to the wrong address. A call checks that the returned address is that of the call itself, not the one after it.

After a halt, the bench keeps presenting instructions, and a design that kept accepting them would move `pc` or the flag. Offsets that should be ignored while `off1_en` is low are set to nonzero values.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

  typedef enum logic [3:0] {
    OP_CEQ   = 4'd0,
    OP_CNE   = 4'd1,
    OP_CGT   = 4'd2,
    OP_CLT   = 4'd3,
    OP_CGE   = 4'd4,
    OP_CLE   = 4'd5,
    OP_ADDCMP = 4'd6,
    OP_GANY  = 4'd7,
    OP_GNONE = 4'd8,
    OP_STAT  = 4'd9,
    OP_JMP   = 4'd10,
    OP_JT    = 4'd11,
    OP_JF    = 4'd12,
    OP_CALL  = 4'd13,
    OP_GETPC = 4'd14,
    OP_HALT  = 4'd15
  } seq_op_e;

  localparam int unsigned DW = 32;

  function automatic logic op_sets_flag(seq_op_e op);
    return op <= OP_STAT;
  endfunction

  function automatic logic op_writes_back(seq_op_e op);
    return (op == OP_ADDCMP) || (op == OP_CALL) || (op == OP_GETPC);
  endfunction

endpackage

// File: rtl/seq_cond_unit.sv
module seq_cond_unit
  import branch_seq_pkg::*;
(
  input  seq_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  c,
  input  logic           gcond,
  input  logic           status2,
  output logic           hit,
  output logic [DW-1:0]  sum
);
  logic signed [DW-1:0] sa, sb, ssum;

  assign sum  = a + b;
  assign sa   = $signed(a);
  assign sb   = $signed(b);
  assign ssum = $signed(sum);

  always_comb begin
    unique case (op)
      OP_CEQ:    hit = (sa == sb);
      OP_CNE:    hit = (sa != sb);
      OP_CGT:    hit = (sa >  sb);
      OP_CLT:    hit = (sa <  sb);
      OP_CGE:    hit = (sa >= sb);
      OP_CLE:    hit = (sa <= sb);
      OP_ADDCMP: hit = (ssum > $signed(c));
      OP_GANY:   hit = gcond;
      OP_GNONE:  hit = ~gcond;
      OP_STAT:   hit = status2;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_target_gen.sv
module seq_target_gen
  import branch_seq_pkg::*;
#(
  parameter int unsigned PCW = 16
) (
  input  logic [PCW-1:0] label,
  input  logic [DW-1:0]  off0,
  input  logic [DW-1:0]  off1,
  input  logic           off1_en,
  output logic [PCW-1:0] tgt
);
  logic [DW-1:0] full;
  logic [DW-1:0] sec;

  assign sec  = off1_en ? off1 : '0;
  assign full = DW'(label) + off0 + sec;
  assign tgt  = full[PCW-1:0];
endmodule

// File: rtl/seq_pc_next.sv
module seq_pc_next
  import branch_seq_pkg::*;
#(
  parameter int unsigned PCW = 16
) (
  input  seq_op_e        op,
  input  logic [PCW-1:0] pc,
  input  logic [PCW-1:0] tgt,
  input  logic           flag,
  output logic [PCW-1:0] nxt
);
  logic [PCW-1:0] seq_pc;

  assign seq_pc = pc + PCW'(1);

  always_comb begin
    unique case (op)
      OP_JMP, OP_CALL: nxt = tgt;
      OP_JT:           nxt = flag  ? tgt : seq_pc;
      OP_JF:           nxt = !flag ? tgt : seq_pc;
      OP_HALT:         nxt = pc;
      default:         nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int unsigned PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [3:0]     op_code,
  input  logic [31:0]    opa,
  input  logic [31:0]    opb,
  input  logic [31:0]    opc,
  input  logic [PCW-1:0] label,
  input  logic [31:0]    off0,
  input  logic [31:0]    off1,
  input  logic           off1_en,
  input  logic           gcond,
  input  logic           status2,
  input  logic [3:0]     halt_code_in,
  output logic [PCW-1:0] pc,
  output logic           flag,
  output logic           wb_valid,
  output logic [31:0]    wb_data,
  output logic           halted,
  output logic [3:0]     halt_code
);
  seq_op_e        op;
  logic           fire;
  logic           hit;
  logic [DW-1:0]  sum;
  logic [PCW-1:0] tgt, nxt;
  logic [PCW-1:0] pc_q;
  logic           flag_q, halted_q, wbv_q;
  logic [3:0]     code_q;
  logic [DW-1:0]  wbd_q;

  assign op       = seq_op_e'(op_code);
  assign op_ready = ~halted_q;
  assign fire     = op_valid & op_ready;

  seq_cond_unit u_cond (
    .op(op), .a(opa), .b(opb), .c(opc),
    .gcond(gcond), .status2(status2), .hit(hit), .sum(sum)
  );

  seq_target_gen #(.PCW(PCW)) u_tgt (
    .label(label), .off0(off0), .off1(off1), .off1_en(off1_en), .tgt(tgt)
  );

  seq_pc_next #(.PCW(PCW)) u_nxt (
    .op(op), .pc(pc_q), .tgt(tgt), .flag(flag_q), .nxt(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      flag_q   <= 1'b0;
      halted_q <= 1'b0;
      code_q   <= '0;
      wbv_q    <= 1'b0;
      wbd_q    <= '0;
    end else begin
      wbv_q <= 1'b0;
      if (fire) begin
        pc_q <= nxt;
        if (op_sets_flag(op)) flag_q <= hit;
        if (op == OP_HALT) begin
          halted_q <= 1'b1;
          code_q   <= halt_code_in;
        end
        if (op_writes_back(op)) begin
          wbv_q <= 1'b1;
          wbd_q <= (op == OP_ADDCMP) ? sum : DW'(pc_q);
        end
      end
    end
  end

  assign pc        = pc_q;
  assign flag      = flag_q;
  assign halted    = halted_q;
  assign halt_code = code_q;
  assign wb_valid  = wbv_q;
  assign wb_data   = wbd_q;
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
  parameter int unsigned PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic           op_ready,
  input logic [3:0]     op_code,
  input logic [PCW-1:0] label,
  input logic [31:0]    off0,
  input logic [31:0]    off1,
  input logic           off1_en,
  input logic [PCW-1:0] pc,
  input logic           flag,
  input logic           wb_valid,
  input logic           halted
);
  logic           take;
  logic [31:0]    want_full;
  logic [PCW-1:0] want_tgt;

  assign take      = op_valid && op_ready;
  assign want_full = 32'(label) + off0 + (off1_en ? off1 : 32'd0);
  assign want_tgt  = want_full[PCW-1:0];

  assert_reset_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> op_ready);

  assert_cmp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_code <= 4'd9) |=> pc == $past(pc) + PCW'(1));

  assert_flag_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_code >= 4'd10) |=> $stable(flag));

  assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_code == 4'd10) |=> pc == $past(want_tgt));

  assert_wb_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !wb_valid);

  assert_wb_kinds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op_code == 4'd6 || op_code == 4'd13 || op_code == 4'd14)) |=> wb_valid);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(flag));

  assert_halt_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !op_ready);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pc) && $stable(flag));
endmodule

bind branch_seq branch_seq_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .label(label), .off0(off0), .off1(off1),
  .off1_en(off1_en), .pc(pc), .flag(flag), .wb_valid(wb_valid),
  .halted(halted)
);

// File: tb/sim_branch_seq.sv
module sim_branch_seq;
  localparam int unsigned PCW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [3:0] op_code = '0;
  logic [31:0] opa = '0, opb = '0, opc = '0, off0 = '0, off1 = '0;
  logic [PCW-1:0] label = '0;
  logic off1_en = 1'b0, gcond = 1'b0, status2 = 1'b0;
  logic [3:0] halt_code_in = '0;
  logic [PCW-1:0] pc;
  logic flag, wb_valid, halted;
  logic [31:0] wb_data;
  logic [3:0] halt_code;

  int n_chk = 0;
  int n_bad = 0;

  logic [PCW-1:0] m_pc;
  logic m_flag, m_halt, m_wbv;
  logic [31:0] m_wbd;
  logic [3:0] m_code;

  always #4 clk = ~clk;

  branch_seq #(.PCW(PCW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .opa(opa), .opb(opb), .opc(opc), .label(label),
    .off0(off0), .off1(off1), .off1_en(off1_en), .gcond(gcond),
    .status2(status2), .halt_code_in(halt_code_in), .pc(pc), .flag(flag),
    .wb_valid(wb_valid), .wb_data(wb_data), .halted(halted),
    .halt_code(halt_code)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op, input logic v);
    if (!v) return "R11";
    if (m_halt) return "R10";
    if (op <= 4'd5) return "R2";
    if (op == 4'd6) return "R3";
    if (op <= 4'd9) return "R4";
    if (op == 4'd10) return "R6";
    if (op <= 4'd12) return "R7";
    if (op <= 4'd14) return "R8";
    return "R10";
  endfunction

  function automatic logic ref_flag(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input logic g, input logic s);
    logic signed [31:0] sa, sb, sc, ss;
    sa = a; sb = b; sc = c; ss = a + b;
    case (op)
      4'd0: return sa == sb;
      4'd1: return sa != sb;
      4'd2: return sa > sb;
      4'd3: return sa < sb;
      4'd4: return sa >= sb;
      4'd5: return sa <= sb;
      4'd6: return ss > sc;
      4'd7: return g;
      4'd8: return !g;
      default: return s;
    endcase
  endfunction

  function automatic logic [PCW-1:0] ref_tgt(input logic [PCW-1:0] l,
      input logic [31:0] o0, input logic [31:0] o1, input logic e);
    logic [31:0] t;
    t = 32'(l) + o0 + (e ? o1 : 32'd0);
    return t[PCW-1:0];
  endfunction

  task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input logic [PCW-1:0] l,
      input logic [31:0] o0, input logic [31:0] o1, input logic e,
      input logic g, input logic s, input logic [3:0] hc);
    string rq;
    logic [PCW-1:0] t;
    op_valid = v; op_code = op; opa = a; opb = b; opc = c; label = l;
    off0 = o0; off1 = o1; off1_en = e; gcond = g; status2 = s; halt_code_in = hc;
    rq = req_of(op, v);
    t = ref_tgt(l, o0, o1, e);
    m_wbv = 1'b0;
    if (v && !m_halt) begin
      if (op <= 4'd9) begin
        m_flag = ref_flag(op, a, b, c, g, s);
        if (op == 4'd6) begin m_wbv = 1'b1; m_wbd = a + b; end
        m_pc = m_pc + 1'b1;
      end else begin
        case (op)
          4'd10: m_pc = t;
          4'd11: m_pc = m_flag ? t : m_pc + 1'b1;
          4'd12: m_pc = !m_flag ? t : m_pc + 1'b1;
          4'd13: begin m_wbv = 1'b1; m_wbd = 32'(m_pc); m_pc = t; end
          4'd14: begin m_wbv = 1'b1; m_wbd = 32'(m_pc); m_pc = m_pc + 1'b1; end
          default: begin m_halt = 1'b1; m_code = hc; end
        endcase
      end
    end
    @(negedge clk);
    op_valid = 1'b0;
    check(pc == m_pc, rq, "pc", 32'(pc), 32'(m_pc));
    check(flag == m_flag, (op >= 4'd10 && v) ? "R5" : rq, "flag", 32'(flag), 32'(m_flag));
    check(wb_valid == m_wbv, "R9", "wb_valid", 32'(wb_valid), 32'(m_wbv));
    if (m_wbv) check(wb_data == m_wbd, rq, "wb_data", wb_data, m_wbd);
    check(halted == m_halt && op_ready == !m_halt, "R10", "halted", 32'(halted), 32'(m_halt));
    if (m_halt) check(halt_code == m_code, "R10", "halt_code", 32'(halt_code), 32'(m_code));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(pc == '0 && flag == 1'b0 && halted == 1'b0 && wb_valid == 1'b0 &&
          halt_code == 4'd0 && op_ready == 1'b1, "R1", "reset state",
          {pc, 3'b0, flag, 3'b0, halted, 3'b0, wb_valid, halt_code}, 32'h1);
    rst_n = 1'b1;
    m_pc = '0; m_flag = 1'b0; m_halt = 1'b0; m_code = '0; m_wbd = '0;
  endtask

  function automatic logic [31:0] pick();
    if ($urandom % 3 == 0) return $urandom;
    return 32'($signed($urandom % 9) - 4);
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R2 signed boundary: -1 vs 1
    step(1, 4'd2, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4'd3, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4'd0, 32'd7, 32'd7, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 wrapped sum: 0x7fffffff+1 is negative, not > 0
    step(1, 4'd6, 32'h7FFF_FFFF, 32'd1, 32'd0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4'd6, 32'd5, 32'd3, 32'd7, 0, 0, 0, 0, 0, 0, 0);
    // R4 status tests
    step(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 4'd9, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R6 second offset ignored when disabled
    step(1, 4'd10, 0, 0, 0, 16'h0100, 32'd5, 32'd99, 0, 0, 0, 0);
    step(1, 4'd10, 0, 0, 0, 16'h0100, 32'hFFFF_FFFE, 32'd9, 1, 0, 0, 0);
    // R7 both senses with flag set, then cleared
    step(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 4'd11, 0, 0, 0, 16'h0200, 0, 0, 0, 0, 0, 0);
    step(1, 4'd12, 0, 0, 0, 16'h0300, 0, 0, 0, 0, 0, 0);
    step(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4'd12, 0, 0, 0, 16'h0300, 32'd4, 0, 0, 0, 0, 0);
    // R8 call returns own address
    step(1, 4'd13, 0, 0, 0, 16'h0400, 32'd1, 32'd2, 1, 0, 0, 0);
    step(1, 4'd14, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 idle cycle with a would-be jump on the bus
    step(0, 4'd10, 0, 0, 0, 16'h0777, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, 4'($urandom % 15), pick(), pick(), pick(),
           PCW'($urandom), pick(), pick(), 1'($urandom), 1'($urandom),
           1'($urandom), 4'($urandom));
    end
    // R10 halt, then attempts that must be ignored
    step(1, 4'd15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'hA);
    step(1, 4'd10, 0, 0, 0, 16'h0055, 0, 0, 0, 0, 0, 0);
    step(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, !m_flag, 0, 0);
    step(1, 4'd15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'h3);
    do_reset();
    step(1, 4'd14, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 200; i++) begin
      step(1'b1, 4'($urandom % 16), pick(), pick(), pick(), PCW'($urandom),
           pick(), pick(), 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
      if (m_halt && ($urandom % 4 == 0)) do_reset();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule